// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache Controller

This block sits between a processor load/store port and a memory bus that can deliver four-word wrapping read bursts. It keeps 4 KB of line storage as 128 sets × 2 ways × 4 words of 32 bits. Next to that storage are a tag, a valid bit and a lock bit for each line, and one replacement bit for each set. A load that hits is answered from the array with no bus traffic. A load that misses picks a victim way and refills it with a burst that starts at the missed word. That word goes to the core as soon as it arrives. Every store is written through to memory.

Address fields: bits [3:2] select the word within a line, bits [10:4] select the set, and bits [30:11] are the tag. Bit 31 marks an access as non-cacheable. When `cfg_en` is low the cache is off. In that state the whole 4 KB array behaves as on-chip RAM, addressed by word through address bits [11:2], and the bus is never used. `cfg_en` is expected low after reset. It is changed only while no request is pending.

Core handshake: the core holds `cpu_req` and its request fields stable until `cpu_ready` is high for one cycle. Bus handshake: each cycle with `mem_ack` high completes one beat. A burst (`mem_burst` high) returns four beats. They come in wrapping order, starting at the word-aligned `mem_addr`.

Top module: `dcache2w`

## Requirements
- R1: During and after reset, `cpu_ready` and `mem_req` are low and every line is invalid, so the first cached load misses.
- R2: A cached load that matches the tag of a valid line in its set completes with `cpu_ready` in the cycle after acceptance, returns the stored word, and issues no bus request.
- R3: A cached load that misses issues one burst read (`mem_burst`=1, `mem_we`=0) whose `mem_addr` is the word-aligned missed address, held stable for the whole burst. The first returned beat is passed to `cpu_rdata` with `cpu_ready` in the same cycle.
- R4: Refill beats are written to word offsets starting at the missed offset and incrementing modulo 4, so later loads to every word of the line hit with the memory contents.
- R5: When a set has an invalid way, the refill goes there. If both ways are invalid, way 0 is used.
- R6: With both ways valid and unlocked, the refill replaces the way not most recently used. Every hit and every refill of a set updates that choice.
- R7: A load with `cpu_lock`=1 locks the line it hits or refills, and a locked line is never replaced. With one way locked the other way is refilled. With both locked the load becomes a single non-burst read and nothing is allocated.
- R8: Every store with the cache on issues a single bus write (`mem_we`=1) of `cpu_wdata` to the word-aligned address. A store that hits also updates the cached word. A store that misses allocates nothing, so the next load to it misses.
- R9: With the cache on, a load with address bit 31 set is a single non-burst read and allocates nothing. A store with bit 31 set does not alter cached lines.
- R10: With `cfg_en` low, loads and stores use array word index `addr[11:2]` (bit 31 ignored), complete without any bus request, and a load returns the last value stored at that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Cache on (1) or array used as RAM (0) |
| cpu_req | input | 1 | Core request, held until `cpu_ready` |
| cpu_we | input | 1 | Store (1) or load (0) |
| cpu_lock | input | 1 | Lock the line a load hits or refills |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request complete this cycle |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write |
| mem_burst | output | 1 | Four-beat wrapping read burst |
| mem_addr | output | 32 | Word-aligned bus address (first beat for a burst) |
| mem_wdata | output | 32 | Bus write data |
| mem_ack | input | 1 | Beat complete |
| mem_rdata | input | 32 | Bus read data, valid with `mem_ack` |

## Verification
A corrupted tag or valid bit shows up on the very next access to that set. A hit turns into a burst, or a miss returns stale data with no bus activity. A wrong replacement bit or lock bit stays hidden until the set fills up. It then appears a few accesses later, as an extra burst on a line that should still be resident, or as a burst where a single read was due. A wrong refill ordering is seen only when the other words of the line are loaded, so every word of a refilled line is loaded back. Each of these accesses is compared with an independent model of set contents, locks and recency.

// File: rtl/dc_pkg.sv
`timescale 1ns/1ps
package dc_pkg;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned SETS       = 128;
    localparam int unsigned LINE_WORDS = 4;

    localparam int unsigned BYTE_OFS = $clog2(WORD_W / 8);
    localparam int unsigned WOFS_W   = $clog2(LINE_WORDS);
    localparam int unsigned SET_W    = $clog2(SETS);
    localparam int unsigned TAG_LO   = BYTE_OFS + WOFS_W + SET_W;
    localparam int unsigned TAG_W    = ADDR_W - 1 - TAG_LO;
    localparam int unsigned IDX_W    = 1 + SET_W + WOFS_W;
    localparam int unsigned DEPTH    = 2 ** IDX_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SET_W-1:0]  set_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WOFS_W-1:0] wofs_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [2:0] {
        S_IDLE, S_LOOK, S_FILL, S_WRITE, S_UNC
    } dc_state_e;

    typedef struct packed {
        logic  we;
        logic  lk;
        addr_t addr;
        word_t wd;
    } dc_req_t;

    function automatic set_t f_set(addr_t a);
        return a[TAG_LO-1 -: SET_W];
    endfunction

    function automatic tag_t f_tag(addr_t a);
        return a[ADDR_W-2 -: TAG_W];
    endfunction

    function automatic wofs_t f_wofs(addr_t a);
        return a[BYTE_OFS +: WOFS_W];
    endfunction

    function automatic idx_t f_ram(addr_t a);
        return a[BYTE_OFS +: IDX_W];
    endfunction

    function automatic logic f_nc(addr_t a);
        return a[ADDR_W-1];
    endfunction
endpackage

// File: rtl/dc_tags.sv
`timescale 1ns/1ps
module dc_tags
    import dc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  set_t set_i,
    input  tag_t tag_i,
    input  logic fill_en,
    input  logic fill_way,
    input  logic fill_lock,
    input  logic touch_en,
    input  logic touch_lock,
    output logic hit_o,
    output logic hit_way_o,
    output logic vict_o,
    output logic all_lck_o,
    output logic [1:0] lck_o
);
    logic [1:0]      hv;
    logic [1:0]      vv;
    logic [SETS-1:0] lru_q;   // per set: way to evict next

    for (genvar w = 0; w < 2; w++) begin : g_way
        tag_t            tag_q [SETS];
        logic [SETS-1:0] vld_q;
        logic [SETS-1:0] lck_q;
        logic            sel_fill;
        logic            sel_lock;

        assign sel_fill = fill_en && (fill_way == 1'(w));
        assign sel_lock = touch_en && touch_lock && hv[w];

        always_ff @(posedge clk) begin
            if (sel_fill) tag_q[set_i] <= tag_i;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
                lck_q <= '0;
            end else if (sel_fill) begin
                vld_q[set_i] <= 1'b1;
                lck_q[set_i] <= fill_lock;
            end else if (sel_lock) begin
                lck_q[set_i] <= 1'b1;
            end
        end

        assign vv[w]    = vld_q[set_i];
        assign lck_o[w] = lck_q[set_i];
        assign hv[w]    = vld_q[set_i] && (tag_q[set_i] == tag_i);
    end

    assign hit_o     = |hv;
    assign hit_way_o = hv[1];
    assign all_lck_o = &lck_o;

    always_comb begin
        if (!vv[0])         vict_o = 1'b0;
        else if (!vv[1])    vict_o = 1'b1;
        else if (lck_o[0])  vict_o = 1'b1;
        else if (lck_o[1])  vict_o = 1'b0;
        else                vict_o = lru_q[set_i];
    end

    always_ff @(posedge clk) begin
        if (rst)           lru_q <= '0;
        else if (fill_en)  lru_q[set_i] <= ~fill_way;
        else if (touch_en) lru_q[set_i] <= ~hit_way_o;
    end
endmodule

// File: rtl/dc_data.sv
`timescale 1ns/1ps
module dc_data
    import dc_pkg::*;
(
    input  logic  clk,
    input  logic  we_i,
    input  idx_t  idx_i,
    input  word_t wd_i,
    output word_t rd_o
);
    word_t arr [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) arr[idx_i] <= wd_i;
    end

    assign rd_o = arr[idx_i];
endmodule

// File: rtl/dcache2w.sv
`timescale 1ns/1ps
module dcache2w
    import dc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_en,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic        cpu_lock,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ready,
    output logic [31:0] cpu_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic        mem_burst,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam wofs_t LAST_BEAT = wofs_t'(LINE_WORDS - 1);

    dc_state_e st_q;
    dc_req_t   req_q;
    logic      way_q;
    wofs_t     beat_q;

    logic  hit, hit_way, vict, all_lck;
    logic [1:0] lck;
    logic  look, nc, cached, rd_hit, wr_hit, fill_ack, fill_last;
    wofs_t fill_wofs;
    idx_t  d_idx;
    logic  d_we;
    word_t d_wd, d_rd;
    set_t  set_a;

    assign set_a     = f_set(req_q.addr);
    assign look      = (st_q == S_LOOK);
    assign nc        = f_nc(req_q.addr);
    assign cached    = look && cfg_en && !nc;
    assign rd_hit    = cached && !req_q.we && hit;
    assign wr_hit    = cached && req_q.we && hit;
    assign fill_ack  = (st_q == S_FILL) && mem_ack;
    assign fill_last = fill_ack && (beat_q == LAST_BEAT);
    assign fill_wofs = f_wofs(req_q.addr) + beat_q;

    dc_tags u_tags (
        .clk       (clk),
        .rst       (rst),
        .set_i     (set_a),
        .tag_i     (f_tag(req_q.addr)),
        .fill_en   (fill_last),
        .fill_way  (way_q),
        .fill_lock (req_q.lk),
        .touch_en  (rd_hit || wr_hit),
        .touch_lock(req_q.lk && !req_q.we),
        .hit_o     (hit),
        .hit_way_o (hit_way),
        .vict_o    (vict),
        .all_lck_o (all_lck),
        .lck_o     (lck)
    );

    always_comb begin
        if (st_q == S_FILL) d_idx = {way_q, set_a, fill_wofs};
        else if (!cfg_en)   d_idx = f_ram(req_q.addr);
        else                d_idx = {hit_way, set_a, f_wofs(req_q.addr)};
    end

    assign d_we = (look && !cfg_en && req_q.we) || wr_hit || fill_ack;
    assign d_wd = (st_q == S_FILL) ? mem_rdata : req_q.wd;

    dc_data u_data (
        .clk  (clk),
        .we_i (d_we),
        .idx_i(d_idx),
        .wd_i (d_wd),
        .rd_o (d_rd)
    );

    always_comb begin
        unique case (st_q)
            S_LOOK:         cpu_ready = !cfg_en || rd_hit;
            S_FILL:         cpu_ready = mem_ack && (beat_q == '0);
            S_WRITE, S_UNC: cpu_ready = mem_ack;
            default:        cpu_ready = 1'b0;
        endcase
    end

    assign cpu_rdata = look ? d_rd : mem_rdata;
    assign mem_req   = (st_q == S_FILL) || (st_q == S_WRITE) || (st_q == S_UNC);
    assign mem_we    = (st_q == S_WRITE);
    assign mem_burst = (st_q == S_FILL);
    assign mem_addr  = req_q.addr & ~addr_t'(WORD_W / 8 - 1);
    assign mem_wdata = req_q.wd;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            req_q  <= '0;
            way_q  <= 1'b0;
            beat_q <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: if (cpu_req) begin
                    req_q <= '{we: cpu_we, lk: cpu_lock, addr: cpu_addr, wd: cpu_wdata};
                    st_q  <= S_LOOK;
                end
                S_LOOK: begin
                    if (!cfg_en)        st_q <= S_IDLE;
                    else if (req_q.we)  st_q <= S_WRITE;
                    else if (nc)        st_q <= S_UNC;
                    else if (hit)       st_q <= S_IDLE;
                    else if (all_lck)   st_q <= S_UNC;
                    else begin
                        st_q   <= S_FILL;
                        way_q  <= vict;
                        beat_q <= '0;
                    end
                end
                S_FILL: if (mem_ack) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == LAST_BEAT) st_q <= S_IDLE;
                end
                S_WRITE, S_UNC: if (mem_ack) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dc_chk.sv
`timescale 1ns/1ps
module dc_chk
    import dc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cfg_en,
    input dc_state_e   st,
    input logic        hit,
    input logic        req_we,
    input logic        req_nc,
    input logic        fill_way,
    input logic [1:0]  lck,
    input logic        cpu_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_burst,
    input logic [31:0] mem_addr
);
    AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (st == S_LOOK && cfg_en && !req_we && !req_nc && hit) |-> (cpu_ready && !mem_req)); // R2
    AST_BURST_IS_READ: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_burst) |-> !mem_we); // R3
    AST_BURST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (st == S_FILL && $past(st) == S_FILL) |-> $stable(mem_addr)); // R3
    AST_FILL_NOT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (st == S_FILL) |-> !lck[fill_way]); // R7
    AST_STORE_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (st == S_LOOK && cfg_en && req_we) |=> (mem_req && mem_we)); // R8
    AST_NC_NO_BURST: assert property (@(posedge clk) disable iff (rst)
        (st == S_LOOK && cfg_en && req_nc) |=> !mem_burst); // R9
    AST_RAM_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (st == S_LOOK && !cfg_en) |-> (cpu_ready && !mem_req)); // R10
endmodule

bind dcache2w dc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .st       (st_q),
    .hit      (hit),
    .req_we   (req_q.we),
    .req_nc   (nc),
    .fill_way (way_q),
    .lck      (lck),
    .cpu_ready(cpu_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_burst(mem_burst),
    .mem_addr (mem_addr)
);

// File: tb/sim_dcache2w.sv
`timescale 1ns/1ps
module sim_dcache2w;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1, cfg_en = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_lock = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, mem_req, mem_we, mem_burst;
    logic [31:0] cpu_rdata, mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    dcache2w u0 (.*);

    int n_chk = 0, n_fail = 0;

    // memory and cache reference state
    logic [31:0] mmem [logic [31:0]];
    logic [19:0] mt  [128][2];
    bit          mv  [128][2];
    bit          ml  [128][2];
    bit          mlru[128];
    logic [31:0] ram [1024];
    int          ev_kind = 0;   // 0 none, 1 burst, 2 single read, 3 write
    logic [31:0] ev_addr = '0;
    int          bcnt = 0;

    function automatic logic [31:0] mrd(logic [31:0] a);
        logic [31:0] k = {a[31:2], 2'b00};
        if (mmem.exists(k)) return mmem[k];
        return (k * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // bus responder: zero-wait beats, driven just after the rising edge
    always @(posedge clk) begin
        #1;
        mem_ack = 1'b0;
        if (!rst && mem_req) begin
            if (mem_we) begin
                mmem[{mem_addr[31:2], 2'b00}] = mem_wdata;
                ev_kind = 3; ev_addr = mem_addr;
            end else if (mem_burst) begin
                if (bcnt == 0) begin ev_kind = 1; ev_addr = mem_addr; end
                mem_rdata = mrd({mem_addr[31:4], 2'(mem_addr[3:2] + 2'(bcnt)), 2'b00});
                bcnt = (bcnt + 1) % 4;
            end else begin
                ev_kind = 2; ev_addr = mem_addr;
                mem_rdata = mrd(mem_addr);
            end
            mem_ack = 1'b1;
        end
    end

    task automatic access(bit we, logic [31:0] a, logic [31:0] wd, bit lk, string rq);
        int s = int'(a[10:4]);
        logic [19:0] t = a[30:11];
        int ek = 0, hw = -1, v, n = 0;
        logic [31:0] ed = '0, got;
        if (!cfg_en) begin
            if (we) ram[a[11:2]] = wd; else ed = ram[a[11:2]];
        end else if (a[31]) begin
            ek = we ? 3 : 2; ed = mrd(a);
        end else begin
            for (int w = 0; w < 2; w++) if (mv[s][w] && mt[s][w] == t) hw = w;
            if (we) begin
                ek = 3;
                if (hw >= 0) mlru[s] = (hw == 0);
            end else if (hw >= 0) begin
                ed = mrd(a); mlru[s] = (hw == 0);
                if (lk) ml[s][hw] = 1'b1;
            end else begin
                ed = mrd(a);
                if (!mv[s][0])                    v = 0;
                else if (!mv[s][1])               v = 1;
                else if (ml[s][0] && ml[s][1])    v = -1;
                else if (ml[s][0])                v = 1;
                else if (ml[s][1])                v = 0;
                else                              v = int'(mlru[s]);
                if (v < 0) ek = 2;
                else begin
                    ek = 1; mt[s][v] = t; mv[s][v] = 1'b1; ml[s][v] = lk; mlru[s] = (v == 0);
                end
            end
        end
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_lock = lk;
        ev_kind = 0;
        do begin @(negedge clk); n++; end while (!cpu_ready && n < 64);
        chk(cpu_ready, rq, "completion", 32'(cpu_ready), 32'd1);
        got = cpu_rdata;
        cpu_req = 1'b0;
        chk(ev_kind == ek, rq, "bus kind", 32'(ev_kind), 32'(ek));
        if (ek != 0) chk(ev_addr == {a[31:2], 2'b00}, rq, "bus addr", ev_addr, {a[31:2], 2'b00});
        if (!we) chk(got == ed, rq, "load data", got, ed);
        if (we && ek == 3) chk(mrd(a) == wd, rq, "memory after store", mrd(a), wd);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!cpu_ready && !mem_req, "R1", "reset outputs", {cpu_ready, mem_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!cpu_ready && !mem_req, "R1", "idle outputs", {cpu_ready, mem_req}, 32'd0);
        cfg_en = 1'b1;
        // first access misses: R1 R3 R5 (way 0, critical word 2)
        access(0, 32'h0000_1028, 0, 0, "R1_R3_R5");
        access(0, 32'h0000_102C, 0, 0, "R4");
        access(0, 32'h0000_1020, 0, 0, "R4");
        access(0, 32'h0000_1024, 0, 0, "R2_R4");
        access(0, 32'h0000_2028, 0, 0, "R5");
        access(0, 32'h0000_1020, 0, 0, "R2_R6");
        access(0, 32'h0000_3024, 0, 0, "R6");
        access(0, 32'h0000_1024, 0, 0, "R6");
        access(0, 32'h0000_2028, 0, 0, "R6");
        access(0, 32'h0000_1028, 0, 0, "R6");
        // write-through
        access(1, 32'h0000_1020, 32'hDEAD_BEEF, 0, "R8");
        access(0, 32'h0000_1020, 0, 0, "R8");
        access(1, 32'h0000_4040, 32'h1357_9BDF, 0, "R8");
        access(0, 32'h0000_4040, 0, 0, "R8");
        // non-cacheable
        access(0, 32'h8000_1028, 0, 0, "R9");
        access(1, 32'h8000_1028, 32'hCAFE_0001, 0, "R9");
        access(0, 32'h0000_1028, 0, 0, "R9");
        access(0, 32'h8000_1028, 0, 0, "R9");
        // locking
        access(0, 32'h0000_0080, 0, 1, "R7");
        access(0, 32'h0000_0880, 0, 0, "R7");
        access(0, 32'h0000_1080, 0, 0, "R7");
        access(0, 32'h0000_0080, 0, 0, "R7");
        access(0, 32'h0000_1080, 0, 1, "R7");
        access(0, 32'h0000_1880, 0, 0, "R7");
        access(0, 32'h0000_1880, 0, 0, "R7");
        access(0, 32'h0000_0080, 0, 0, "R7");
        access(0, 32'h0000_1080, 0, 0, "R7");
        // RAM mode
        repeat (6) @(negedge clk);
        cfg_en = 1'b0;
        access(1, 32'h0000_0000, 32'hA0A0_0000, 0, "R10");
        access(1, 32'h0000_0FFC, 32'hB1B1_0FFC, 0, "R10");
        access(1, 32'h8000_0010, 32'hC2C2_0010, 0, "R10");
        access(0, 32'h0000_0FFC, 0, 0, "R10");
        access(0, 32'h0000_0000, 0, 0, "R10");
        access(0, 32'h0000_0010, 0, 0, "R10");
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule